// File: doc/BRIEF.md
# Two-Pass Black-Level Offset Calibrator

This block runs an automatic offset calibration for the front end of a line-scan digitizer. When calibration is requested, it switches the variable-gain stage off and loads the offset DAC with a +7 LSB preload. The preload keeps the total offset above zero, so the ADC can measure it. It also clears the offset-add flag. It then measures the black level twice: once with the programmable gain code at 0 (x1) and once at all ones (x2).

Each measurement is the integer average of the valid pixels of one complete black line. Sampling starts at the first line-start marker seen after the gain is set, and the average is taken at the line-end marker. From the two averages, named B1 (x1) and B2 (x2), the block computes the final DAC code as 7 + B1 − B2, clamped to the DAC range. It sets the add flag when 2·B1 < B2.

At completion, the block restores the gain code that was in effect when calibration started and turns the gain stage back on. It then pulses `done` while the results are on its outputs.

Top module: `ofscal_seq`

## Requirements
- R1: One cycle after `cal_start` is sampled while idle, `busy` is 1, `vga_en` is 0, `dac_code` is 7, `ofs_add` is 0 and `pga_code` is 0. These values hold until the second pass starts.
- R2: B1 is the floor of (sum of the valid samples ÷ their count) over the first complete line captured at gain code 0.
- R3: After the first line's line-end marker, `pga_code` changes to all ones (127), and the second line is averaged in the same way to give B2.
- R4: A line-end marker that arrives before any line-start marker after a gain change does not close a measurement. `pga_code` stays 0, and the samples before that marker do not enter B1.
- R5: Samples with `pix_valid` low are left out of both the sum and the count.
- R6: When 7 + B1 − B2 lies in 0..2^DAC_W−1, `dac_code` equals that value at completion and `cal_err` is 0, provided both lines had valid pixels.
- R7: `ofs_add` is 1 when 2·B1 < B2 and 0 otherwise, including when 2·B1 = B2. The comparison uses the full width of 2·B1.
- R8: When 7 + B1 − B2 is below 0, `dac_code` becomes 0. When it is above 2^DAC_W−1, `dac_code` becomes 2^DAC_W−1. In both cases `cal_err` is 1.
- R9: A line with no valid pixel gives an average of 0 and sets `cal_err` to 1.
- R10: At completion, `done` is high for exactly one cycle. In that cycle `busy` is 0, `vga_en` is 1 and `pga_code` equals `gain_code_req` as sampled at start.
- R11: A `cal_start` pulse while `busy` is high is ignored. The running calibration keeps its gain code and its result.
- R12: After reset, `busy`, `done`, `ofs_add`, `cal_err` and `dac_code` are 0 and `vga_en` is 1. While idle, `pga_code` follows `gain_code_req` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Pulse that begins a calibration |
| gain_code_req | input | PGA_W | Gain code used outside calibration |
| pix_data | input | ADC_W | ADC sample |
| pix_valid | input | 1 | Sample belongs to the valid pixel area |
| line_start | input | 1 | First sample of a line |
| line_end | input | 1 | Last sample of a line |
| dac_code | output | DAC_W | Offset DAC code |
| ofs_add | output | 1 | Offset-add flag |
| pga_code | output | PGA_W | Programmable gain code |
| vga_en | output | 1 | Variable-gain stage enable |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Clamping occurred or a line had no valid pixels |

## Verification
Directed black levels are chosen to land on each branch of the result logic:
- a mid-range case;
- the exact 2·B1 = B2 tie;
- a case with 2·B1 < B2;
- a clamp above the DAC range;
- a clamp below zero;
- full-scale samples, where a truncated 2·B1 would flip the add flag.

Lines with scattered invalid pixels carry full-scale data on the invalid slots, so any leak of those samples into the average shows up as a wrong DAC code. A line-end marker sent without a line-start marker shows whether a partial line can close a pass. Lines with no valid pixel and a second start pulse during a pass cover the error path and the ignored restart. Random levels and validity patterns then exercise the floor division across many sum and count pairs.

// File: rtl/ofscal_pkg.sv
package ofscal_pkg;
    localparam int ADC_W_DEF   = 8;
    localparam int DAC_W_DEF   = 4;
    localparam int PGA_W_DEF   = 7;
    localparam int CNT_W_DEF   = 6;
    localparam int DAC_PRELOAD = 7;

    typedef enum logic [1:0] {SQ_IDLE, SQ_PASS1, SQ_PASS2} seq_st_t;
    typedef enum logic [1:0] {AV_IDLE, AV_WAIT, AV_ACC, AV_DIV} avg_st_t;
endpackage

// File: rtl/ofscal_divider.sv
module ofscal_divider #(
    parameter int N  = 14,
    parameter int D  = 6,
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [N-1:0]  dividend,
    input  logic [D-1:0]  divisor,
    output logic          done,
    output logic [QW-1:0] quot
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  dvd;
    logic [D-1:0]  rem, dsr;
    logic [QW-1:0] q;
    logic [CW-1:0] steps;
    logic          run;
    logic [D:0]    shifted, trial;
    logic          fits;

    always_comb begin
        shifted = {rem, dvd[N-1]};
        fits    = shifted >= {1'b0, dsr};
        trial   = fits ? (shifted - {1'b0, dsr}) : shifted;
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            run   <= 1'b0;
            dvd   <= '0;
            rem   <= '0;
            dsr   <= '0;
            q     <= '0;
            steps <= '0;
        end else if (start) begin
            run   <= 1'b1;
            dvd   <= dividend;
            dsr   <= divisor;
            rem   <= '0;
            q     <= '0;
            steps <= CW'(N);
        end else if (run) begin
            dvd   <= dvd << 1;
            rem   <= trial[D-1:0];
            q     <= {q[QW-2:0], fits};
            steps <= steps - 1'b1;
            if (steps == CW'(1)) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assign quot = q;
endmodule

// File: rtl/ofscal_line_avg.sv
module ofscal_line_avg import ofscal_pkg::*; #(
    parameter int ADC_W = ADC_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [ADC_W-1:0] pix_data,
    input  logic             pix_valid,
    input  logic             line_start,
    input  logic             line_end,
    output logic             avg_done,
    output logic [ADC_W-1:0] avg_val,
    output logic             avg_zero
);
    localparam int SUM_W = ADC_W + CNT_W;

    avg_st_t          st;
    logic [SUM_W-1:0] sum, sum_nxt, first_sum;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             div_go, div_done;
    logic [ADC_W-1:0] quot;

    always_comb begin
        first_sum = pix_valid ? SUM_W'(pix_data) : '0;
        sum_nxt   = sum + first_sum;
        cnt_nxt   = cnt + CNT_W'(pix_valid);
        div_go    = (st == AV_ACC) && line_end && (cnt_nxt != '0);
    end

    ofscal_divider #(.N(SUM_W), .D(CNT_W), .QW(ADC_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend (sum_nxt),
        .divisor  (cnt_nxt),
        .done     (div_done),
        .quot     (quot)
    );

    always_ff @(posedge clk) begin
        avg_done <= 1'b0;
        if (rst) begin
            st       <= AV_IDLE;
            sum      <= '0;
            cnt      <= '0;
            avg_val  <= '0;
            avg_zero <= 1'b0;
        end else begin
            case (st)
                AV_IDLE: if (arm) st <= AV_WAIT;
                AV_WAIT: if (line_start) begin
                    sum <= first_sum;
                    cnt <= CNT_W'(pix_valid);
                    st  <= AV_ACC;
                end
                AV_ACC: begin
                    sum <= sum_nxt;
                    cnt <= cnt_nxt;
                    if (line_end) begin
                        if (cnt_nxt == '0) begin
                            avg_val  <= '0;
                            avg_zero <= 1'b1;
                            avg_done <= 1'b1;
                            st       <= AV_IDLE;
                        end else begin
                            avg_zero <= 1'b0;
                            st       <= AV_DIV;
                        end
                    end
                end
                AV_DIV: if (div_done) begin
                    avg_val  <= quot;
                    avg_done <= 1'b1;
                    st       <= AV_IDLE;
                end
                default: st <= AV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ofscal_seq.sv
module ofscal_seq import ofscal_pkg::*; #(
    parameter int ADC_W = ADC_W_DEF,
    parameter int DAC_W = DAC_W_DEF,
    parameter int PGA_W = PGA_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_start,
    input  logic [PGA_W-1:0] gain_code_req,
    input  logic [ADC_W-1:0] pix_data,
    input  logic             pix_valid,
    input  logic             line_start,
    input  logic             line_end,
    output logic [DAC_W-1:0] dac_code,
    output logic             ofs_add,
    output logic [PGA_W-1:0] pga_code,
    output logic             vga_en,
    output logic             busy,
    output logic             done,
    output logic             cal_err
);
    localparam int XW      = ADC_W + 2;
    localparam int DAC_MAX = (1 << DAC_W) - 1;

    seq_st_t                st;
    logic                   arm, avg_done, avg_zero, b1_zero;
    logic [ADC_W-1:0]       avg_val, b1;
    logic [PGA_W-1:0]       saved_pga;
    logic signed [XW-1:0]   raw;
    logic                   sat_lo, sat_hi, add_nxt;
    logic [DAC_W-1:0]       code_nxt;

    assign arm = ((st == SQ_IDLE) && cal_start) || ((st == SQ_PASS1) && avg_done);

    ofscal_line_avg #(.ADC_W(ADC_W), .CNT_W(CNT_W)) u_avg (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .pix_data   (pix_data),
        .pix_valid  (pix_valid),
        .line_start (line_start),
        .line_end   (line_end),
        .avg_done   (avg_done),
        .avg_val    (avg_val),
        .avg_zero   (avg_zero)
    );

    // Result arithmetic on B1 (held) and B2 (arriving from the averager).
    always_comb begin
        raw     = $signed(XW'(DAC_PRELOAD)) + $signed({2'b00, b1}) - $signed({2'b00, avg_val});
        sat_lo  = raw < 0;
        sat_hi  = raw > $signed(XW'(DAC_MAX));
        add_nxt = {b1, 1'b0} < {1'b0, avg_val};
        if (sat_lo)      code_nxt = '0;
        else if (sat_hi) code_nxt = '1;
        else             code_nxt = raw[DAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            st        <= SQ_IDLE;
            dac_code  <= '0;
            ofs_add   <= 1'b0;
            pga_code  <= '0;
            vga_en    <= 1'b1;
            busy      <= 1'b0;
            cal_err   <= 1'b0;
            b1        <= '0;
            b1_zero   <= 1'b0;
            saved_pga <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    pga_code <= gain_code_req;
                    if (cal_start) begin
                        saved_pga <= gain_code_req;
                        pga_code  <= '0;
                        dac_code  <= DAC_W'(DAC_PRELOAD);
                        ofs_add   <= 1'b0;
                        vga_en    <= 1'b0;
                        busy      <= 1'b1;
                        cal_err   <= 1'b0;
                        st        <= SQ_PASS1;
                    end
                end
                SQ_PASS1: if (avg_done) begin
                    b1       <= avg_val;
                    b1_zero  <= avg_zero;
                    pga_code <= '1;
                    st       <= SQ_PASS2;
                end
                SQ_PASS2: if (avg_done) begin
                    dac_code <= code_nxt;
                    ofs_add  <= add_nxt;
                    cal_err  <= b1_zero | avg_zero | sat_lo | sat_hi;
                    pga_code <= saved_pga;
                    vga_en   <= 1'b1;
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    st       <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ofscal_seq_chk.sv
module ofscal_seq_chk #(
    parameter int DAC_W = 4,
    parameter int PGA_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cal_start,
    input logic [DAC_W-1:0] dac_code,
    input logic             ofs_add,
    input logic [PGA_W-1:0] pga_code,
    input logic             vga_en,
    input logic             busy,
    input logic             done
);
    // R1
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!vga_en && dac_code == DAC_W'(7) && !ofs_add));

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_start && !busy) |=> busy);

    // R3
    busy_gain_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pga_code == '0 || pga_code == '1));

    // R10
    done_state_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && vga_en));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    finish_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind ofscal_seq ofscal_seq_chk #(.DAC_W(DAC_W), .PGA_W(PGA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cal_start (cal_start),
    .dac_code  (dac_code),
    .ofs_add   (ofs_add),
    .pga_code  (pga_code),
    .vga_en    (vga_en),
    .busy      (busy),
    .done      (done)
);

// File: tb/ofscal_seq_test.sv
module ofscal_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_start = 1'b0;
    logic [6:0] gain_code_req = '0;
    logic [7:0] pix_data = '0;
    logic       pix_valid = 1'b0, line_start = 1'b0, line_end = 1'b0;
    logic [3:0] dac_code;
    logic       ofs_add, vga_en, busy, done, cal_err;
    logic [6:0] pga_code;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ofscal_seq uut (
        .clk(clk), .rst(rst), .cal_start(cal_start), .gain_code_req(gain_code_req),
        .pix_data(pix_data), .pix_valid(pix_valid), .line_start(line_start),
        .line_end(line_end), .dac_code(dac_code), .ofs_add(ofs_add),
        .pga_code(pga_code), .vga_en(vga_en), .busy(busy), .done(done),
        .cal_err(cal_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_raw(input int a1, input int a2);
        return 7 + a1 - a2;
    endfunction

    function automatic int exp_dac(input int a1, input int a2);
        int r = exp_raw(a1, a2);
        return (r < 0) ? 0 : ((r > 15) ? 15 : r);
    endfunction

    task automatic feed_line(input int npix, input int base, input int spread, input int vpct,
                             input bit none, output int avg, output bit zero);
        int sum = 0;
        int cnt = 0;
        for (int i = 0; i < npix; i++) begin
            int v;
            @(negedge clk);
            line_start = (i == 0);
            line_end   = (i == npix - 1);
            pix_valid  = !none && (int'($urandom % 100) < vpct);
            v = base + int'($urandom % (spread + 1));
            if (v > 255) v = 255;
            if (pix_valid) begin
                pix_data = 8'(v);
                sum += v;
                cnt++;
            end else begin
                pix_data = 8'hFF; // R5: invalid slots carry full scale
            end
        end
        @(negedge clk);
        line_start = 0; line_end = 0; pix_valid = 0; pix_data = 0;
        avg  = (cnt == 0) ? 0 : sum / cnt;
        zero = (cnt == 0);
    endtask

    task automatic run_cal(input int n1, input int b1, input int s1, input int v1, input bit z1,
                           input int n2, input int b2, input int s2, input int v2, input bit z2,
                           input bit partial, input bit restart);
        int  a1, a2;
        bit  e1, e2, seen;
        int  g, r;
        g = int'($urandom % 128);
        @(negedge clk);
        gain_code_req = 7'(g);
        @(negedge clk);
        cal_start = 1;
        @(negedge clk);
        cal_start = 0;
        check(busy && !vga_en, "R1 busy/vga_en", {busy, vga_en}, 2);
        check(dac_code == 7 && !ofs_add, "R1 preload", dac_code, 7);
        check(pga_code == 0, "R1 gain x1", pga_code, 0);
        gain_code_req = 7'(g ^ 7'h55);
        if (partial) begin
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                pix_valid = 1; pix_data = 8'd200; line_end = (i == 4);
            end
            @(negedge clk);
            pix_valid = 0; line_end = 0; pix_data = 0;
            repeat (25) @(negedge clk);
            check(pga_code == 0, "R4 partial line ignored", pga_code, 0);
        end
        repeat (2) @(negedge clk);
        feed_line(n1, b1, s1, v1, z1, a1, e1);
        seen = 0;
        for (int i = 0; i < 100 && !seen; i++) begin
            if (pga_code == 7'h7F) seen = 1;
            else @(negedge clk);
        end
        check(seen, "R3 gain x2 after first line", pga_code, 127);
        if (restart) begin
            cal_start = 1;
            @(negedge clk);
            cal_start = 0;
            repeat (2) @(negedge clk);
            check(pga_code == 7'h7F && busy, "R11 restart ignored", pga_code, 127);
        end
        repeat (2) @(negedge clk);
        feed_line(n2, b2, s2, v2, z2, a2, e2);
        seen = 0;
        for (int i = 0; i < 100 && !seen; i++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        check(seen, "R10 done pulse", done, 1);
        r = exp_raw(a1, a2);
        if (r < 0 || r > 15)
            check(dac_code == exp_dac(a1, a2), "R8 clamped code", dac_code, exp_dac(a1, a2));
        else
            check(dac_code == exp_dac(a1, a2), "R6/R2 dac code", dac_code, exp_dac(a1, a2));
        check(ofs_add == (2 * a1 < a2), "R7 add flag", ofs_add, int'(2 * a1 < a2));
        if (e1 || e2)
            check(cal_err == 1, "R9 zero-pixel error", cal_err, 1);
        else
            check(cal_err == (r < 0 || r > 15), "R8 error flag", cal_err, int'(r < 0 || r > 15));
        check(pga_code == 7'(g), "R10 gain restored", pga_code, g);
        check(vga_en && !busy, "R10 vga_en/busy", {vga_en, busy}, 2);
        @(negedge clk);
        check(!done, "R10 single-cycle done", done, 0);
        check(pga_code == gain_code_req, "R12 idle tracking", pga_code, gain_code_req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !done && vga_en, "R12 reset flags", {busy, done, vga_en}, 1);
        check(dac_code == 0 && !ofs_add && !cal_err, "R12 reset outputs", dac_code, 0);
        gain_code_req = 7'd42;
        @(negedge clk);
        @(negedge clk);
        check(pga_code == 7'd42, "R12 idle tracking", pga_code, 42);

        run_cal(20, 10, 4, 70, 0, 20, 14, 4, 70, 0, 0, 0); // mid range
        run_cal(16, 4, 0, 60, 0, 16, 8, 0, 60, 0, 0, 0);   // R7 tie 2*B1 == B2
        run_cal(16, 3, 0, 80, 0, 16, 8, 0, 80, 0, 0, 0);   // R7 add = 1
        run_cal(24, 40, 0, 50, 0, 24, 20, 0, 50, 0, 0, 0); // R8 high clamp
        run_cal(24, 10, 0, 50, 0, 24, 30, 0, 50, 0, 0, 0); // R8 low clamp
        run_cal(12, 5, 0, 100, 0, 12, 0, 0, 0, 1, 0, 0);   // R9 no valid pixel
        run_cal(40, 255, 0, 100, 0, 40, 255, 0, 100, 0, 0, 0); // R7 full scale
        run_cal(18, 12, 6, 75, 0, 18, 15, 6, 75, 0, 1, 1); // R4, R11
        for (int k = 0; k < 8; k++) begin
            int bb1 = int'($urandom % 60);
            int bb2 = bb1 + int'($urandom % 20);
            run_cal(8 + int'($urandom % 30), bb1, int'($urandom % 25), 30 + int'($urandom % 70), 0,
                    8 + int'($urandom % 30), bb2, int'($urandom % 25), 30 + int'($urandom % 70), 0,
                    0, 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule